// File: doc/BRIEF.md
# National-to-packed-BCD converter unit

This execution unit turns a signed decimal number written as sixteen-bit characters into a signed packed-BCD value and a four-bit condition field. The operand carries eight characters. The least significant character is a sign character, either '+' (0x002B) or '-' (0x002D). The seven characters above it are digit characters in the range '0' to '9' (0x0030 to 0x0039). The unit takes the low nibble of each digit character and places it in the nibble position that matches its element. It places a sign code in nibble 0 and classifies the result as less than, greater than or equal to zero.

A malformed operand still gives a result. A bad sign character, or any digit character outside the legal range, flags the operand as invalid. Packing stops at the lowest-numbered bad digit, so that nibble and every nibble above it stay zero. For an invalid operand the condition field reports only the summary-overflow bit, and the partial result is still delivered.

The unit has one register stage. A strobe on `in_valid` captures the converted value, and `out_valid` goes high in the following cycle. The captured outputs hold until the next strobe.

Top module: `nat2bcd_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result` and `cond` are all zero.
- R2: `out_valid` is high in exactly those cycles that directly follow a cycle with `in_valid` high.
- R3: For a valid operand, result nibble i (bits 4i+3:4i) equals the low nibble of operand element i (bits 16i+15:16i), for i from 1 to 7.
- R4: Result nibble 0 is 0xC when the sign character is 0x002B and `plus_alt` is 0. It is 0xF when the sign character is 0x002B and `plus_alt` is 1. For any other sign character it is 0xD.
- R5: A sign character other than 0x002B or 0x002D makes `cond` equal 4'b0001 (SO). The digits are still packed as in R3.
- R6: A digit character is valid only within 0x0030 to 0x0039. At the lowest element holding an invalid digit, that nibble and all higher nibbles up to position 7 are zero, and `cond` is 4'b0001.
- R7: For a valid operand whose digit nibbles 1 to 7 are all zero, `cond` is 4'b0010 (EQ) for either sign.
- R8: For a valid operand with a nonzero digit, `cond` is 4'b0100 (GT) when the sign is positive and 4'b1000 (LT) when it is negative. `cond` is ordered {LT, GT, EQ, SO} from MSB to LSB, and exactly one of its bits is set whenever `out_valid` is high.
- R9: Result nibbles 8 to 31 (bits 127:32) are always zero.
- R10: `result` and `cond` keep their values in any cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand strobe |
| operand | input | 128 | Eight 16-bit characters; element 0 is the sign |
| plus_alt | input | 1 | Selects the positive sign code: 0 gives 0xC, 1 gives 0xF |
| out_valid | output | 1 | High one cycle after `in_valid` |
| result | output | 128 | Signed packed-BCD value |
| cond | output | 4 | Condition bits {LT, GT, EQ, SO} |

## Verification
The conversion and its classification both appear on `result` and `cond` in the cycle after the `in_valid` strobe, together with `out_valid`. The bench drives each operand on a falling edge and holds the strobe for one cycle. It checks all three outputs on the next falling edge, after the single capturing rising edge has passed. It then changes the operand with the strobe low and checks one cycle later that `out_valid` has dropped and the captured values did not move. The sweep covers every sign character class, both sign-code selections and every position of a first bad digit, over several digit patterns.

// File: rtl/nat_bcd_pkg.sv
package nat_bcd_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned SIGN_PLUS  = 32'h2B;
  localparam int unsigned SIGN_MINUS = 32'h2D;
  localparam int unsigned CHAR_ZERO  = 32'h30;
  localparam int unsigned CHAR_NINE  = 32'h39;
  localparam logic [3:0] CODE_PLUS_STD = 4'hC;
  localparam logic [3:0] CODE_PLUS_ALT = 4'hF;
  localparam logic [3:0] CODE_MINUS    = 4'hD;
  // condition field bit positions, MSB to LSB: LT GT EQ SO
  localparam int unsigned COND_LT = 3;
  localparam int unsigned COND_GT = 2;
  localparam int unsigned COND_EQ = 1;
  localparam int unsigned COND_SO = 0;
  typedef logic [3:0] cond_t;
endpackage

// File: rtl/nat_char_check.sv
module nat_char_check
  import nat_bcd_pkg::*;
#(
  parameter int unsigned CHAR_W = 16
) (
  input  logic [CHAR_W-1:0] char_in,
  output logic              is_digit,
  output logic [NIB_W-1:0]  nibble
);
  always_comb begin
    is_digit = (char_in >= CHAR_W'(CHAR_ZERO)) && (char_in <= CHAR_W'(CHAR_NINE));
    nibble   = char_in[NIB_W-1:0];
  end

  always_comb begin
    assert_digit_range_R6: assert (!is_digit || (nibble <= 4'd9));
  end
endmodule

// File: rtl/nat_digit_packer.sv
module nat_digit_packer
  import nat_bcd_pkg::*;
#(
  parameter int unsigned NUM_DIG = 7
) (
  input  logic [NUM_DIG-1:0]       dig_ok,
  input  logic [NUM_DIG*NIB_W-1:0] dig_nib,
  output logic [NUM_DIG*NIB_W-1:0] packed_dig,
  output logic                     all_ok
);
  logic [NUM_DIG-1:0] keep;

  // scan upward; a digit is kept only if it and all below it are legal
  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < NUM_DIG; i++) begin
      run     = run & dig_ok[i];
      keep[i] = run;
    end
    all_ok = run;
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_pack
    assign packed_dig[g*NIB_W +: NIB_W] = keep[g] ? dig_nib[g*NIB_W +: NIB_W] : '0;
  end

  always_comb begin
    assert_scan_stop_R6: assert (all_ok || (packed_dig[NUM_DIG*NIB_W-1 -: NIB_W] == '0));
  end
endmodule

// File: rtl/nat_sign_class.sv
module nat_sign_class
  import nat_bcd_pkg::*;
#(
  parameter int unsigned CHAR_W  = 16,
  parameter int unsigned NUM_DIG = 7
) (
  input  logic [CHAR_W-1:0]        sign_char,
  input  logic                     plus_alt,
  input  logic [NUM_DIG*NIB_W-1:0] packed_dig,
  input  logic                     digits_ok,
  output logic [NIB_W-1:0]         sign_code,
  output cond_t                    cond
);
  logic is_plus, is_minus, mag_zero, valid_op;

  always_comb begin
    is_plus   = (sign_char == CHAR_W'(SIGN_PLUS));
    is_minus  = (sign_char == CHAR_W'(SIGN_MINUS));
    valid_op  = (is_plus || is_minus) && digits_ok;
    mag_zero  = (packed_dig == '0);
    sign_code = is_plus ? (plus_alt ? CODE_PLUS_ALT : CODE_PLUS_STD) : CODE_MINUS;
    cond      = '0;
    if (!valid_op)     cond[COND_SO] = 1'b1;
    else if (mag_zero) cond[COND_EQ] = 1'b1;
    else if (is_plus)  cond[COND_GT] = 1'b1;
    else               cond[COND_LT] = 1'b1;
  end

  always_comb begin
    assert_onehot_R8: assert ($countones(cond) == 1);
  end
endmodule

// File: rtl/nat2bcd_unit.sv
module nat2bcd_unit
  import nat_bcd_pkg::*;
#(
  parameter int unsigned CHAR_W    = 16,
  parameter int unsigned NUM_CHARS = 8,
  localparam int unsigned VEC_W    = CHAR_W * NUM_CHARS,
  localparam int unsigned NUM_DIG  = NUM_CHARS - 1,
  localparam int unsigned PACK_W   = NUM_CHARS * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] operand,
  input  logic             plus_alt,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [3:0]       cond
);
  logic [NUM_DIG-1:0]       dig_ok;
  logic [NUM_DIG*NIB_W-1:0] dig_nib;
  logic [NUM_DIG*NIB_W-1:0] packed_dig;
  logic                     all_ok;
  logic [NIB_W-1:0]         sign_code;
  cond_t                    cond_c;

  for (genvar e = 1; e < NUM_CHARS; e++) begin : g_char
    nat_char_check #(.CHAR_W(CHAR_W)) u_chk (
      .char_in  (operand[e*CHAR_W +: CHAR_W]),
      .is_digit (dig_ok[e-1]),
      .nibble   (dig_nib[(e-1)*NIB_W +: NIB_W])
    );
  end

  nat_digit_packer #(.NUM_DIG(NUM_DIG)) u_pack (
    .dig_ok     (dig_ok),
    .dig_nib    (dig_nib),
    .packed_dig (packed_dig),
    .all_ok     (all_ok)
  );

  nat_sign_class #(.CHAR_W(CHAR_W), .NUM_DIG(NUM_DIG)) u_cls (
    .sign_char  (operand[CHAR_W-1:0]),
    .plus_alt   (plus_alt),
    .packed_dig (packed_dig),
    .digits_ok  (all_ok),
    .sign_code  (sign_code),
    .cond       (cond_c)
  );

  // next-state
  logic [VEC_W-1:0] result_d;
  cond_t            cond_d;
  logic             vld_d;

  always_comb begin
    vld_d    = in_valid;
    result_d = result;
    cond_d   = cond;
    if (in_valid) begin
      result_d             = '0;
      result_d[PACK_W-1:0] = {packed_dig, sign_code};
      cond_d               = cond_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cond      <= '0;
    end else begin
      out_valid <= vld_d;
      result    <= result_d;
      cond      <= cond_d;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(cond)));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[VEC_W-1:PACK_W] == '0));
  assert_eq_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cond[COND_EQ]) |-> (result[PACK_W-1:NIB_W] == '0));
  assert_lt_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cond[COND_LT]) |-> (result[NIB_W-1:0] == CODE_MINUS));
  assert_cond_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(cond) == 1));
endmodule

// File: tb/nat2bcd_unit_tb.sv
module nat2bcd_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] operand;
  logic         plus_alt;
  logic         out_valid;
  logic [127:0] result;
  logic [3:0]   cond;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nat2bcd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .plus_alt(plus_alt), .out_valid(out_valid), .result(result), .cond(cond)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference from requirements
  task automatic model(input logic [127:0] op, input logic alt,
                       output logic [127:0] r, output logic [3:0] c);
    logic ok, pos, neg;
    logic [15:0] ch;
    r   = '0;
    ok  = 1'b1;
    ch  = op[15:0];
    pos = (ch == 16'h002B);
    neg = (ch == 16'h002D);
    for (int i = 1; i < 8; i++) begin
      ch = op[i*16 +: 16];
      if (ok && ch >= 16'h0030 && ch <= 16'h0039) r[i*4 +: 4] = ch[3:0];
      else ok = 1'b0;
    end
    r[3:0] = pos ? (alt ? 4'hF : 4'hC) : 4'hD;
    if (!(ok && (pos || neg)))  c = 4'b0001;
    else if (r[31:4] == '0)     c = 4'b0010;
    else if (pos)               c = 4'b0100;
    else                        c = 4'b1000;
  endtask

  task automatic run_vec(input logic [127:0] op, input logic alt, input string tag);
    logic [127:0] er, held_r;
    logic [3:0]   ec, held_c;
    model(op, alt, er, ec);
    @(negedge clk);
    operand  = op;
    plus_alt = alt;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({"R2 out_valid ", tag}, {127'd0, out_valid}, 128'd1);
    check({"R3/R4/R6/R9 result ", tag}, result, er);
    check({"R5/R7/R8 cond ", tag}, {124'd0, cond}, {124'd0, ec});
    held_r  = result;
    held_c  = cond;
    operand = ~op;
    plus_alt = ~alt;
    @(negedge clk);
    check({"R2 idle ", tag}, {127'd0, out_valid}, 128'd0);
    check({"R10 hold ", tag}, {result[123:0], cond}, {held_r[123:0], held_c});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0]  signs [5];
    logic [15:0]  bads  [3];
    logic [127:0] op;
    logic [15:0]  lfsr;
    signs = '{16'h002B, 16'h002D, 16'h0030, 16'h0000, 16'h002C};
    bads  = '{16'h002F, 16'h003A, 16'h0135};
    lfsr  = 16'hACE1;
    rst_n = 1'b0; in_valid = 1'b0; operand = '1; plus_alt = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset result", result, 128'd0);
    check("R1 reset cond", {124'd0, cond}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_vec({112'h0035_0034_0033_0032_0031_0030_0039, 16'h002B}, 1'b0, "R3 plus std");
    run_vec({112'h0030_0030_0030_0030_0030_0030_0030, 16'h002D}, 1'b1, "R7 neg zero");
    run_vec({112'h0030_0030_0030_0031_0030_0030_0030, 16'h002D}, 1'b0, "R8 neg one");
    run_vec({112'h0039_0039_0039_0039_0039_0039_0039, 16'h0058}, 1'b1, "R5 bad sign");
    run_vec({112'h0039_0039_0039_003A_0039_0039_0039, 16'h002B}, 1'b1, "R6 stop");
    // sweep: sign class x select x bad position x digit pattern
    for (int s = 0; s < 5; s++)
      for (int a = 0; a < 2; a++)
        for (int p = 0; p < 8; p++)
          for (int k = 0; k < 4; k++) begin
            op = '0;
            op[15:0] = signs[s];
            for (int i = 1; i < 8; i++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              case (k)
                0: op[i*16 +: 16] = 16'h0030;
                1: op[i*16 +: 16] = 16'h0039;
                2: op[i*16 +: 16] = 16'h0030 + 16'(lfsr[3:0] % 10);
                default: op[i*16 +: 16] = (i == 7) ? 16'h0031 : 16'h0030;
              endcase
            end
            if (p != 0) op[p*16 +: 16] = bads[(p + k) % 3];
            // R4 R5 R6 R7 R8 swept
            run_vec(op, a[0], $sformatf("sweep s%0d a%0d p%0d k%0d", s, a, p, k));
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule